// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This controller collects a set of interrupt request lines and decides which one the processor should enter next. Each line has its own 3-bit urgency setting, from 0 (most urgent) to 7 (least urgent). A rising edge on a line marks it pending. At that moment the controller also stores a copy of the line's current urgency setting. All later decisions for that request use this stored copy. If software rewrites the setting while the request waits or runs, the new value applies only from the next assertion of the line.

The controller compares the best pending request against the level now in service. When nothing is in service, the running level counts as 8. If the pending request is strictly more urgent, the controller raises a request carrying its vector. The processor takes that vector with an entry-acknowledge pulse. A running handler that is interrupted this way is pushed onto an internal nesting stack. When the new handler sends its end-of-service pulse, the stack is popped and the preempted handler resumes at its own level. A simple register strobe lets software set a line's urgency, set its pending bit or clear its pending bit.

The service sequencer is a two-state machine. In IDLE nothing is in service; the transition ENTER, taken on an accepted acknowledge, leads to RUN. In RUN the transition PREEMPT (an accepted acknowledge) pushes the current handler and stays in RUN. The transition RESUME (end-of-service with a non-empty stack) pops the stack and stays in RUN. The transition RETIRE (end-of-service with an empty stack) returns to IDLE.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, no line is pending, `run_level` is 8 (idle), `run_vector` is 0, `nest_depth` is 0, `req_valid` is low, and every urgency setting is 7.
- R2: A line becomes pending on the cycle after its input is first sampled high, following a sample that was low. A line held high sets pending only once.
- R3: `req_valid` is high exactly when some pending line's stored level is numerically lower than `run_level`. `req_vector` then names the pending line with the lowest stored level.
- R4: When several pending lines share the lowest stored level, `req_vector` is the lowest-numbered of them.
- R5: An `entry_ack` while `req_valid` is high clears the pending bit of `req_vector`. That line becomes the running vector, at its stored level. An `entry_ack` while `req_valid` is low has no effect.
- R6: An acknowledge taken while a handler runs pushes that handler and raises `nest_depth` by one. A pending line whose level equals the running level never raises a request.
- R7: `svc_done` while in service pops the nesting stack and restores the previous vector and level, or returns to idle if the stack is empty. `svc_done` while idle has no effect. When `entry_ack` is accepted in the same cycle, `svc_done` is ignored.
- R8: The level stored for a request is the line's urgency setting as it was just before the cycle in which the request was marked pending. Rewriting the setting changes neither a waiting request nor a running handler.
- R9: A strobe with `cfg_op`=0 writes `cfg_prio` as the urgency setting of line `cfg_idx`. `cfg_op`=1 marks the line pending and stores its current setting as the request's level. `cfg_op`=2 clears its pending bit. When a set and a clear of the same line occur in one cycle, the set wins.
- R10: A new rising edge on a line that is running or stacked marks it pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Interrupt request lines, synchronous to clk |
| cfg_we | input | 1 | Register strobe |
| cfg_op | input | 2 | 0 write urgency, 1 set pending, 2 clear pending |
| cfg_idx | input | IDX_W | Line addressed by the strobe |
| cfg_prio | input | 3 | Urgency value for a write (0 most urgent) |
| entry_ack | input | 1 | Processor takes the requested vector |
| svc_done | input | 1 | End-of-service pulse from the running handler |
| req_valid | output | 1 | A more urgent request than the running level exists |
| req_vector | output | IDX_W | Line to enter when req_valid is high |
| run_level | output | 4 | Level in service, 8 when idle |
| run_vector | output | IDX_W | Line in service, 0 when idle |
| nest_depth | output | CNT_W | Number of preempted handlers on the stack |
| pending | output | N_LINES | Pending bit per line |

## Verification
A corrupted stored level shows up as a wrong preemption decision. Depending on the error, `req_valid` either rises in the cycle after the pending bit is set or stays low when it should rise. A fault in the nesting stack stays hidden until the next end-of-service pulse; then `run_level`, `run_vector` and `nest_depth` go wrong in the cycle right after it. The bench therefore compares every output on every cycle against a behavioural model. It drives long preemption chains so that stack faults surface, and it also drives equal-level waiting and mid-service urgency rewrites.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    // Urgency field width is fixed: eight levels, 0 most urgent.
    localparam int PRIO_W   = 3;
    localparam int LVL_W    = PRIO_W + 1;
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(1 << PRIO_W);

    typedef enum logic [1:0] {
        CFG_PRIO = 2'd0,
        CFG_SET  = 2'd1,
        CFG_CLR  = 2'd2,
        CFG_NOP  = 2'd3
    } cfg_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } svc_state_e;
endpackage

// File: rtl/nirq_pend_track.sv
module nirq_pend_track
    import nirq_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_LINES-1:0]               irq_in,
    input  logic                             prio_we,
    input  logic                             set_we,
    input  logic                             clr_we,
    input  logic [IDX_W-1:0]                 sw_idx,
    input  logic [PRIO_W-1:0]                sw_prio,
    input  logic                             ack_clr,
    input  logic [IDX_W-1:0]                 ack_idx,
    output logic [N_LINES-1:0]               pend_o,
    output logic [N_LINES-1:0][PRIO_W-1:0]   snap_o
);
    // One slice per request line: edge detect, urgency register,
    // pending flag and the level captured when the request arrived.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic              irq_d;
        logic [PRIO_W-1:0] prio_q;
        logic              pend_q;
        logic [PRIO_W-1:0] snap_q;
        logic              sel_sw;
        logic              sel_ack;
        logic              rise;
        logic              set_now;
        logic              clr_now;

        assign sel_sw  = (sw_idx == IDX_W'(g));
        assign sel_ack = ack_clr && (ack_idx == IDX_W'(g));
        assign rise    = irq_in[g] && !irq_d;
        assign set_now = rise || (set_we && sel_sw);
        assign clr_now = sel_ack || (clr_we && sel_sw);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_d  <= 1'b0;
                prio_q <= '1;
                pend_q <= 1'b0;
                snap_q <= '1;
            end else begin
                irq_d <= irq_in[g];
                if (prio_we && sel_sw) begin
                    prio_q <= sw_prio;
                end
                if (set_now) begin
                    pend_q <= 1'b1;
                    snap_q <= prio_q;   // value before this cycle's write
                end else if (clr_now) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pend_o[g] = pend_q;
        assign snap_o[g] = snap_q;
    end
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
    import nirq_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_LINES-1:0]             pend,
    input  logic [N_LINES-1:0][PRIO_W-1:0] snap,
    output logic                           best_valid,
    output logic [IDX_W-1:0]               best_idx,
    output logic [PRIO_W-1:0]              best_lvl
);
    // Linear scan from line 0 upward; strict comparison keeps the
    // lowest index among equal levels.
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_lvl   = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (pend[i] && (!best_valid || (snap[i] < best_lvl))) begin
                best_valid = 1'b1;
                best_idx   = IDX_W'(i);
                best_lvl   = snap[i];
            end
        end
    end
endmodule

// File: rtl/nirq_stack.sv
module nirq_stack #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 7,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top_data,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    assign wr_ptr = PTR_W'(cnt_q);
    assign rd_ptr = PTR_W'(cnt_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && (cnt_q != CNT_W'(DEPTH))) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push && (cnt_q != CNT_W'(DEPTH))) begin
            mem[wr_ptr] <= push_data;
        end
    end

    assign top_data = (cnt_q != '0) ? mem[rd_ptr] : '0;
    assign count    = cnt_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter  int N_LINES     = 8,
    parameter  int STACK_DEPTH = 8,
    localparam int IDX_W       = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_op,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [2:0]         cfg_prio,
    input  logic               entry_ack,
    input  logic               svc_done,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_vector,
    output logic [3:0]         run_level,
    output logic [IDX_W-1:0]   run_vector,
    output logic [CNT_W-1:0]   nest_depth,
    output logic [N_LINES-1:0] pending
);
    localparam int ENT_W = IDX_W + LVL_W;

    cfg_op_e                        op;
    logic                           prio_we, set_we, clr_we;
    logic [N_LINES-1:0]             pend;
    logic [N_LINES-1:0][PRIO_W-1:0] snap;
    logic                           best_valid;
    logic [IDX_W-1:0]               best_idx;
    logic [PRIO_W-1:0]              best_lvl;
    logic                           take;
    logic                           push, pop;
    logic [ENT_W-1:0]               top_data;
    logic [CNT_W-1:0]               stk_cnt;

    svc_state_e       state_q, state_d;
    logic [LVL_W-1:0] run_lvl_q, run_lvl_d;
    logic [IDX_W-1:0] run_vec_q, run_vec_d;

    assign op      = cfg_op_e'(cfg_op);
    assign prio_we = cfg_we && (op == CFG_PRIO);
    assign set_we  = cfg_we && (op == CFG_SET);
    assign clr_we  = cfg_we && (op == CFG_CLR);

    nirq_pend_track #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .prio_we (prio_we),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .sw_idx  (cfg_idx),
        .sw_prio (cfg_prio),
        .ack_clr (take),
        .ack_idx (best_idx),
        .pend_o  (pend),
        .snap_o  (snap)
    );

    nirq_arbiter #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_arb (
        .pend       (pend),
        .snap       (snap),
        .best_valid (best_valid),
        .best_idx   (best_idx),
        .best_lvl   (best_lvl)
    );

    // Preemption only for a strictly lower level number; idle is level 8.
    assign req_valid = best_valid && ({1'b0, best_lvl} < run_lvl_q);
    assign take      = entry_ack && req_valid;
    assign push      = take && (state_q == ST_RUN);
    assign pop       = !take && svc_done && (state_q == ST_RUN) && (stk_cnt != '0);

    nirq_stack #(.DEPTH(STACK_DEPTH), .DATA_W(ENT_W), .CNT_W(CNT_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data ({run_vec_q, run_lvl_q}),
        .top_data  (top_data),
        .count     (stk_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            run_lvl_q <= IDLE_LVL;
            run_vec_q <= '0;
        end else begin
            state_q   <= state_d;
            run_lvl_q <= run_lvl_d;
            run_vec_q <= run_vec_d;
        end
    end

    // Transitions: ENTER, PREEMPT, RESUME, RETIRE
    always_comb begin
        state_d   = state_q;
        run_lvl_d = run_lvl_q;
        run_vec_d = run_vec_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin                       // ENTER
                    state_d   = ST_RUN;
                    run_lvl_d = {1'b0, best_lvl};
                    run_vec_d = best_idx;
                end
            end
            ST_RUN: begin
                if (take) begin                       // PREEMPT
                    run_lvl_d = {1'b0, best_lvl};
                    run_vec_d = best_idx;
                end else if (svc_done) begin
                    if (stk_cnt != '0) begin          // RESUME
                        run_lvl_d = top_data[LVL_W-1:0];
                        run_vec_d = top_data[ENT_W-1:LVL_W];
                    end else begin                    // RETIRE
                        state_d   = ST_IDLE;
                        run_lvl_d = IDLE_LVL;
                        run_vec_d = '0;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_vector = best_idx;
    assign run_level  = run_lvl_q;
    assign run_vector = run_vec_q;
    assign nest_depth = stk_cnt;
    assign pending    = pend;
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
    parameter int N_LINES     = 8,
    parameter int STACK_DEPTH = 8,
    parameter int IDX_W       = 3,
    parameter int CNT_W       = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_in,
    input logic               entry_ack,
    input logic               svc_done,
    input logic               req_valid,
    input logic [IDX_W-1:0]   req_vector,
    input logic [3:0]         run_level,
    input logic [IDX_W-1:0]   run_vector,
    input logic [CNT_W-1:0]   nest_depth,
    input logic [N_LINES-1:0] pending
);
    assert_idle_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_level == 4'd8) |-> (nest_depth == '0));

    for (genvar g = 0; g < N_LINES; g++) begin : g_edge
        assert_edge_pends_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_in[g]) |=> pending[g]);
    end

    assert_req_is_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (pending[req_vector] && (run_level != 4'd0)));

    assert_ack_enters_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_ack && req_valid) |=> (run_vector == $past(req_vector)));

    assert_preempt_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_ack && req_valid && (run_level != 4'd8))
        |=> (nest_depth == $past(nest_depth) + CNT_W'(1)));

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= CNT_W'(STACK_DEPTH));

    assert_idle_done_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && !entry_ack && (run_level == 4'd8))
        |=> ((run_level == 4'd8) && $stable(nest_depth)));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .N_LINES     (N_LINES),
    .STACK_DEPTH (STACK_DEPTH),
    .IDX_W       (IDX_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .entry_ack  (entry_ack),
    .svc_done   (svc_done),
    .req_valid  (req_valid),
    .req_vector (req_vector),
    .run_level  (run_level),
    .run_vector (run_vector),
    .nest_depth (nest_depth),
    .pending    (pending)
);

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/100ps
module test_nest_irq_ctrl;
    localparam int N     = 8;
    localparam int DEPTH = 8;
    localparam int IW    = 3;
    localparam int CW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = 2'd0;
    logic [IW-1:0] cfg_idx = '0;
    logic [2:0]    cfg_prio = '0;
    logic          entry_ack = 1'b0;
    logic          svc_done = 1'b0;
    logic          req_valid;
    logic [IW-1:0] req_vector;
    logic [3:0]    run_level;
    logic [IW-1:0] run_vector;
    logic [CW-1:0] nest_depth;
    logic [N-1:0]  pending;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl #(.N_LINES(N), .STACK_DEPTH(DEPTH)) i_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
        .entry_ack(entry_ack), .svc_done(svc_done), .req_valid(req_valid),
        .req_vector(req_vector), .run_level(run_level), .run_vector(run_vector),
        .nest_depth(nest_depth), .pending(pending)
    );

    // ---------------- behavioural reference ----------------
    int m_prio [N];
    int m_snap [N];
    bit m_pend [N];
    bit m_prev [N];
    int m_lvl;
    int m_vec;
    int m_stk [$];

    function automatic void m_best(output bit v, output int idx, output int lvl);
        v = 0; idx = 0; lvl = 7;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && (!v || m_snap[i] < lvl)) begin
                v = 1; idx = i; lvl = m_snap[i];
            end
    endfunction

    always @(posedge clk) begin
        bit bv; int bi; int bl; bit req;
        int old_p [N];
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 7; m_snap[i] = 7; m_pend[i] = 0; m_prev[i] = 0;
            end
            m_lvl = 8; m_vec = 0; m_stk.delete();
        end else begin
            m_best(bv, bi, bl);
            req = bv && (bl < m_lvl);
            for (int i = 0; i < N; i++) old_p[i] = m_prio[i];
            if (entry_ack && req) begin
                if (m_lvl != 8) m_stk.push_back(m_vec * 16 + m_lvl);
                m_lvl = bl; m_vec = bi; m_pend[bi] = 0;
            end else if (svc_done && m_lvl != 8) begin
                if (m_stk.size() > 0) begin
                    int e;
                    e = m_stk.pop_back();
                    m_vec = e / 16; m_lvl = e % 16;
                end else begin
                    m_lvl = 8; m_vec = 0;
                end
            end
            if (cfg_we && cfg_op == 2'd0) m_prio[cfg_idx] = cfg_prio;
            if (cfg_we && cfg_op == 2'd2) m_pend[cfg_idx] = 0;
            if (cfg_we && cfg_op == 2'd1) begin
                m_pend[cfg_idx] = 1; m_snap[cfg_idx] = old_p[cfg_idx];
            end
            for (int i = 0; i < N; i++) begin
                if (irq_in[i] && !m_prev[i]) begin
                    m_pend[i] = 1; m_snap[i] = old_p[i];
                end
                m_prev[i] = irq_in[i];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit bv; int bi; int bl; bit req;
            m_best(bv, bi, bl);
            req = bv && (bl < m_lvl);
            chk("R3 req_valid", int'(req_valid), int'(req));
            if (req) chk("R3 req_vector", int'(req_vector), bi);
            chk("R5 run_level", int'(run_level), m_lvl);
            chk("R5 run_vector", int'(run_vector), m_vec);
            chk("R6 nest_depth", int'(nest_depth), m_stk.size());
            for (int i = 0; i < N; i++) chk("R2 pending", int'(pending[i]), int'(m_pend[i]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfg(input int op, input int idx, input int val);
        @(negedge clk);
        cfg_we = 1; cfg_op = 2'(op); cfg_idx = IW'(idx); cfg_prio = 3'(val);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse(input logic [N-1:0] m);
        @(negedge clk); irq_in = m;
        @(negedge clk); irq_in = '0;
    endtask

    task automatic ack();
        @(negedge clk); entry_ack = 1;
        @(negedge clk); entry_ack = 0;
    endtask

    task automatic done_pulse();
        @(negedge clk); svc_done = 1;
        @(negedge clk); svc_done = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 req_valid", int'(req_valid), 0);
        chk("R1 run_level", int'(run_level), 8);
        chk("R1 nest_depth", int'(nest_depth), 0);
        chk("R1 pending", int'(pending), 0);

        cfg(0, 3, 5); cfg(0, 5, 2); cfg(0, 1, 4); cfg(0, 6, 4); cfg(0, 7, 1);

        pulse(8'h08);
        chk("R2 pending line3", int'(pending[3]), 1);
        chk("R3 vector 3", int'(req_vector), 3);
        ack();
        chk("R5 run level 5", int'(run_level), 5);
        chk("R5 pending cleared", int'(pending[3]), 0);
        pulse(8'h20);
        chk("R3 preempt request", int'(req_valid), 1);
        ack();
        chk("R6 depth 1", int'(nest_depth), 1);
        chk("R6 run level 2", int'(run_level), 2);
        pulse(8'h08);
        chk("R10 stacked line re-pends", int'(pending[3]), 1);
        done_pulse();
        chk("R7 resume vector 3", int'(run_vector), 3);
        chk("R7 resume level 5", int'(run_level), 5);
        chk("R6 equal level waits", int'(req_valid), 0);
        done_pulse();
        chk("R7 retire to idle", int'(run_level), 8);
        chk("R3 waiting line requests", int'(req_valid), 1);
        ack(); done_pulse();
        done_pulse();
        chk("R7 idle done ignored", int'(run_level), 8);
        ack();
        chk("R5 ack without request", int'(run_level), 8);

        // R4 tie, then R8 snapshot
        pulse(8'h42);
        chk("R4 lowest index wins", int'(req_vector), 1);
        ack();
        cfg(0, 6, 0);
        chk("R8 rewrite does not preempt", int'(req_valid), 0);
        done_pulse();
        ack();
        chk("R8 stored level used", int'(run_level), 4);
        cfg(1, 7, 0);
        chk("R9 sw set requests", int'(req_valid), 1);
        chk("R9 sw set vector", int'(req_vector), 7);
        cfg(2, 7, 0);
        chk("R9 sw clear", int'(pending[7]), 0);
        done_pulse();
        pulse(8'h40); ack();
        chk("R8 new assertion uses new value", int'(run_level), 0);
        done_pulse();

        // Deep preemption chain
        for (int i = 0; i < N; i++) cfg(0, i, 7 - i);
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            ack();
        end
        chk("R6 depth 7", int'(nest_depth), 7);
        chk("R6 level 0", int'(run_level), 0);
        for (int i = 0; i < N; i++) done_pulse();
        chk("R7 unwound", int'(run_level), 8);

        // R2 held-high line sets pending once
        @(negedge clk); irq_in = 8'h04;
        @(negedge clk);
        ack(); done_pulse();
        repeat (3) @(negedge clk);
        chk("R2 held high no re-latch", int'(pending[2]), 0);
        irq_in = '0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule